// File: doc/BRIEF.md
# Split-Screen Line Start Address Reload

This block produces the character memory address for a character-row video timing chain. It keeps a stored line-start address. Each scanline, a working address counter reloads from that stored value and then steps once for every displayed character. The horizontal, vertical-character and raster counters come from an external timing generator, along with its total, displayed, last-row, last-raster and start-address settings. The block decides, from these inputs, when the stored address changes and which value it takes.

Three events can replace the stored address:
- A row end, found by adding a soft-scroll offset to the raster count.
- The end of a frame.
- A programmable split, which lets software restart the display from an arbitrary address part way down the screen.

The split is armed by an 8-bit line number and a two-byte address that the CPU writes. The split compare uses an 8-bit scanline counter that wraps. On a frame taller than 256 lines, one programmed value can therefore match twice.

Top module: `split_ma_reload`

## Requirements
- R1: The split line register is 8 bits wide, resets to 0, and a value of 0 never causes a split capture.
- R2: The split address is written as two bytes. The high byte supplies address bits [13:8], and its upper two bits are dropped. The low byte supplies bits [7:0].
- R3: On the cycle with `hcc`=0 the working address loads the line base. For `hcc` from 1 to `r1` it increments by one each cycle. After that it holds until the next line.
- R4: On a line whose scanline number equals a nonzero split value, the split address is captured when `hcc`=`r1`. It becomes the base of the following line, and later rows continue from it.
- R5: On the last raster of the last character row (`vcc`=`r4`, `rcc`=`r9`, outside adjust), the split capture happens at `hcc`=`r0` instead. It wins over the frame-end load, so it is used on the second line of the next frame.
- R6: The first line of a frame (`vcc`=0, `rcc`=0, not in adjust) always takes its base from `start_addr`, whatever the stored address holds.
- R7: Outside vertical adjust, when (`rcc`+`scroll`) mod 32 equals `r9`, the stored address takes the working address value reached at `hcc`=`r1` (line base + `r1`).
- R8: At `hcc`=`r0` on a line with `last_line`=1, the stored address is loaded from `start_addr`, unless a split captures in the same cycle.
- R9: The scanline counter is 0 on the first line of a frame and counts lines modulo 256. On a 312-line frame the value 37h matches both line 55 and line 311.
- R10: During vertical adjust, a split may capture only while `rcc` is 8 or less. The row-end raster match is inactive throughout adjust.
- R11: After reset the working address and the stored address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcc | input | 8 | Horizontal character count |
| vcc | input | 7 | Vertical character-row count |
| rcc | input | 5 | Raster count within row, or adjust line count |
| in_adj | input | 1 | High during vertical total adjust lines |
| last_line | input | 1 | High during the final scanline of the frame |
| r0 | input | 8 | Horizontal total (last `hcc` value) |
| r1 | input | 8 | Characters displayed per line |
| r4 | input | 7 | Last character row of the frame |
| r9 | input | 5 | Last raster of a character row |
| scroll | input | 5 | Soft-scroll raster offset |
| start_addr | input | 14 | Frame start address |
| wr_line | input | 1 | Write strobe for the split line register |
| wr_hi | input | 1 | Write strobe for the split address high byte |
| wr_lo | input | 1 | Write strobe for the split address low byte |
| wdata | input | 8 | Write data |
| ma | output | 14 | Working memory address |

## Verification
The working address is registered, so its value for a given `hcc` is visible one clock after that count is presented. The bench samples 1 ns after that edge and compares against the line base plus min(`hcc`, `r1`).

A capture of the stored address shows nowhere on the same line. It appears only at the next line's `hcc`=0 sample, one clock after that count. The bench therefore updates its line-level model of the stored address only after the whole line has been checked.

Register writes take effect one clock after the strobe. They are placed at `hcc` 1 to 3 of a frame's first line, ahead of that line's capture column.

// File: rtl/crtc_split_pkg.sv
package crtc_split_pkg;

  // Source of the next stored line-start address.
  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_ROW   = 2'd1,
    SRC_FRAME = 2'd2,
    SRC_SPLIT = 2'd3
  } src_e;

  // Priority when several events hit in one cycle: split, frame end, row end.
  function automatic src_e pick_src(input logic split_cap, input logic frame_ld,
                                    input logic row_ld);
    if (split_cap)     return SRC_SPLIT;
    else if (frame_ld) return SRC_FRAME;
    else if (row_ld)   return SRC_ROW;
    else               return SRC_KEEP;
  endfunction

endpackage

// File: rtl/split_cfg_regs.sv
module split_cfg_regs #(
  parameter int AW = 14,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_line,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [7:0]    wdata,
  output logic [LW-1:0] split_line,
  output logic [AW-1:0] split_addr
);
  localparam int HIW = AW - 8;

  logic [LW-1:0]  line_q;
  logic [HIW-1:0] hi_q;
  logic [7:0]     lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (wr_line) line_q <= wdata[LW-1:0];
      if (wr_hi)   hi_q   <= wdata[HIW-1:0];
      if (wr_lo)   lo_q   <= wdata;
    end
  end

  assign split_line = line_q;
  assign split_addr = {hi_q, lo_q};
endmodule

// File: rtl/split_line_ctr.sv
module split_line_ctr #(
  parameter int HW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcc,
  input  logic [HW-1:0] r0,
  input  logic          last_line,
  output logic [LW-1:0] line_q
);
  logic [LW-1:0] cnt_q;

  // Modulo 2^LW scanline count, restarted at every frame end.
  function automatic logic [LW-1:0] line_step(input logic [LW-1:0] cur,
                                              input logic frame_end);
    return frame_end ? '0 : LW'(cur + 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (hcc == r0) cnt_q <= line_step(cnt_q, last_line);
  end

  assign line_q = cnt_q;
endmodule

// File: rtl/ma_row_store.sv
module ma_row_store
  import crtc_split_pkg::*;
#(
  parameter int AW = 14,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcc,
  input  logic [HW-1:0] r1,
  input  logic          first_line,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] split_addr,
  input  logic          split_cap,
  input  logic          frame_ld,
  input  logic          row_ld,
  output logic [AW-1:0] ma
);
  logic [AW-1:0] stored_q;
  logic [AW-1:0] ma_q;
  logic [AW-1:0] ma_nxt;
  logic [AW-1:0] line_base;
  src_e          src;

  // Line start loads the base; displayed characters step; the rest holds.
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] cur,
                                              input logic [HW-1:0] h,
                                              input logic [HW-1:0] lim,
                                              input logic [AW-1:0] base);
    if (h == '0)      return base;
    else if (h <= lim) return AW'(cur + 1'b1);
    else              return cur;
  endfunction

  always_comb begin
    line_base = first_line ? start_addr : stored_q;
    ma_nxt    = next_addr(ma_q, hcc, r1, line_base);
    src       = pick_src(split_cap, frame_ld, row_ld);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma_q     <= '0;
      stored_q <= '0;
    end else begin
      ma_q <= ma_nxt;
      case (src)
        SRC_SPLIT: stored_q <= split_addr;
        SRC_FRAME: stored_q <= start_addr;
        SRC_ROW:   stored_q <= ma_nxt;
        default:   stored_q <= stored_q;
      endcase
    end
  end

  assign ma = ma_q;
endmodule

// File: rtl/split_ma_reload.sv
module split_ma_reload #(
  parameter int AW      = 14,
  parameter int HW      = 8,
  parameter int VW      = 7,
  parameter int RW      = 5,
  parameter int LW      = 8,
  parameter int ADJ_MAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcc,
  input  logic [VW-1:0] vcc,
  input  logic [RW-1:0] rcc,
  input  logic          in_adj,
  input  logic          last_line,
  input  logic [HW-1:0] r0,
  input  logic [HW-1:0] r1,
  input  logic [VW-1:0] r4,
  input  logic [RW-1:0] r9,
  input  logic [RW-1:0] scroll,
  input  logic [AW-1:0] start_addr,
  input  logic          wr_line,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] ma
);
  localparam logic [RW-1:0] ADJ_LIM = RW'(ADJ_MAX);

  logic [LW-1:0] split_line;
  logic [AW-1:0] split_addr;
  logic [LW-1:0] line_q;

  // Named events, visible to the bound checker.
  logic          last_row_line;
  logic [HW-1:0] cap_col;
  logic          adj_ok;
  logic          split_hit;
  logic          split_cap_w;
  logic          frame_ld_w;
  logic          row_ld_w;
  logic          first_line_w;

  // Row end: raster count offset by soft scroll, modulo 2^RW.
  function automatic logic raster_end(input logic [RW-1:0] r, input logic [RW-1:0] s,
                                      input logic [RW-1:0] last);
    logic [RW-1:0] sum;
    sum = RW'(r + s);
    return sum == last;
  endfunction

  always_comb begin
    last_row_line = (vcc == r4) && (rcc == r9) && !in_adj;
    cap_col       = last_row_line ? r0 : r1;
    adj_ok        = !in_adj || (rcc <= ADJ_LIM);
    split_hit     = (split_line != '0) && (line_q == split_line) && adj_ok;
    split_cap_w   = split_hit && (hcc == cap_col);
    frame_ld_w    = last_line && (hcc == r0);
    row_ld_w      = !in_adj && (hcc == r1) && raster_end(rcc, scroll, r9);
    first_line_w  = (vcc == '0) && (rcc == '0) && !in_adj;
  end

  split_cfg_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_line(wr_line), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wdata(wdata), .split_line(split_line), .split_addr(split_addr)
  );

  split_line_ctr #(.HW(HW), .LW(LW)) u_line (
    .clk(clk), .rst_n(rst_n), .hcc(hcc), .r0(r0), .last_line(last_line),
    .line_q(line_q)
  );

  ma_row_store #(.AW(AW), .HW(HW)) u_store (
    .clk(clk), .rst_n(rst_n), .hcc(hcc), .r1(r1), .first_line(first_line_w),
    .start_addr(start_addr), .split_addr(split_addr), .split_cap(split_cap_w),
    .frame_ld(frame_ld_w), .row_ld(row_ld_w), .ma(ma)
  );
endmodule

// File: rtl/split_ma_chk.sv
module split_ma_chk #(
  parameter int AW = 14,
  parameter int HW = 8,
  parameter int VW = 7,
  parameter int RW = 5,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hcc,
  input logic [VW-1:0] vcc,
  input logic [RW-1:0] rcc,
  input logic          in_adj,
  input logic          last_line,
  input logic [HW-1:0] r0,
  input logic [HW-1:0] r1,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] ma,
  input logic [LW-1:0] line_q,
  input logic [LW-1:0] split_line,
  input logic          split_cap
);
  // R3
  ma_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcc != '0 && hcc <= r1) |=> ma == AW'($past(ma) + 1'b1));

  // R3
  ma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcc > r1) |=> $stable(ma));

  // R6
  frame_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcc == '0 && vcc == '0 && rcc == '0 && !in_adj) |=> ma == $past(start_addr));

  // R9
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcc == r0 && !last_line) |=> line_q == LW'($past(line_q) + 1'b1));

  // R9
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcc == r0 && last_line) |=> line_q == '0);

  // R1
  split_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_cap |-> split_line != '0);

  // R10
  adj_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_adj && rcc > RW'(8)) |-> !split_cap);

  // R4
  cap_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_cap |-> (hcc == r1 || hcc == r0));
endmodule

bind split_ma_reload split_ma_chk #(.AW(AW), .HW(HW), .VW(VW), .RW(RW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hcc(hcc), .vcc(vcc), .rcc(rcc), .in_adj(in_adj),
  .last_line(last_line), .r0(r0), .r1(r1), .start_addr(start_addr), .ma(ma),
  .line_q(line_q), .split_line(split_line), .split_cap(split_cap_w)
);

// File: tb/sim_split_ma_reload.sv
module sim_split_ma_reload;
  localparam int R0V = 7;
  localparam int R1V = 4;
  localparam int R9V = 7;
  localparam logic [13:0] START = 14'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hcc = '0;
  logic [6:0]  vcc = '0;
  logic [4:0]  rcc = '0;
  logic        in_adj = 1'b0;
  logic        last_line = 1'b0;
  logic [7:0]  r0 = 8'(R0V);
  logic [7:0]  r1 = 8'(R1V);
  logic [6:0]  r4 = 7'd38;
  logic [4:0]  r9 = 5'(R9V);
  logic [4:0]  scroll = '0;
  logic [13:0] start_addr = START;
  logic        wr_line = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
  logic [7:0]  wdata = '0;
  logic [13:0] ma;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // Line-level reference state.
  int          idx = 0;
  logic [13:0] stor = '0;
  string       btag = "R11";
  string       row_tag = "R7";
  int          sl = 0;
  int          scr = 0;
  logic [7:0]  w_line = '0, w_hi = '0, w_lo = '0;
  logic [13:0] saddr = '0;

  always #5 clk = ~clk;

  split_ma_reload u0 (
    .clk(clk), .rst_n(rst_n), .hcc(hcc), .vcc(vcc), .rcc(rcc), .in_adj(in_adj),
    .last_line(last_line), .r0(r0), .r1(r1), .r4(r4), .r9(r9), .scroll(scroll),
    .start_addr(start_addr), .wr_line(wr_line), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wdata(wdata), .ma(ma)
  );

  task automatic chk(input logic [13:0] exp, input string tag);
    nchk++;
    if (ma !== exp) begin
      nerr++;
      $display("FAIL %s: ma=%h expected %h (line %0d)", tag, ma, exp, idx);
    end
  endtask

  task automatic do_line(input int v, input int r, input bit a, input bit last,
                         input bit wr, input int r4v);
    logic [13:0] base;
    string       tag;
    bit          first, hit, allow, cap_r0;
    first = (v == 0 && r == 0 && !a);
    base  = first ? START : stor;
    tag   = first ? "R6" : btag;
    for (int h = 0; h <= R0V; h++) begin
      hcc = 8'(h); vcc = 7'(v); rcc = 5'(r); in_adj = a; last_line = last;
      wr_line = wr && h == 1; wr_hi = wr && h == 2; wr_lo = wr && h == 3;
      wdata = (h == 1) ? w_line : (h == 2) ? w_hi : w_lo;
      @(posedge clk); #1;
      chk(14'(base + ((h < R1V) ? h : R1V)), (h == 0) ? tag : "R3");
    end
    wr_line = 0; wr_hi = 0; wr_lo = 0;
    // Events on this line, in column order.
    hit    = (sl != 0) && ((idx % 256) == sl);
    allow  = !a || r <= 8;
    cap_r0 = (v == r4v) && (r == R9V) && !a;
    if (!a && ((r + scr) % 32) == R9V) begin stor = 14'(base + R1V); btag = row_tag; end
    if (hit && allow && !cap_r0) begin
      stor = saddr;
      btag = a ? "R10" : (idx >= 256) ? "R9" : "R4 R2";
    end
    if (last) begin stor = START; btag = "R8"; end
    if (hit && allow && cap_r0) begin stor = saddr; btag = "R5"; end
    if (hit && !allow) btag = "R10";
    idx = last ? 0 : idx + 1;
  endtask

  task automatic run_frame(input int r4v, input int adj, input int line_v,
                           input logic [7:0] hi_v, input logic [7:0] lo_v);
    w_line = 8'(line_v); w_hi = hi_v; w_lo = lo_v;
    sl = line_v; saddr = {hi_v[5:0], lo_v};
    r4 = 7'(r4v); scroll = 5'(scr);
    for (int v = 0; v <= r4v; v++)
      for (int r = 0; r <= R9V; r++)
        do_line(v, r, 1'b0, adj == 0 && v == r4v && r == R9V, v == 0 && r == 0, r4v);
    for (int k = 0; k < adj; k++)
      do_line(r4v + 1, k, 1'b1, k == adj - 1, 1'b0, r4v);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(14'h0000, "R11");
    rst_n = 1'b1;
    // Split disabled, first frame after reset.
    run_frame(38, 0, 0, 8'h00, 8'h00);
    row_tag = "R1 R7";
    run_frame(38, 0, 0, 8'h3F, 8'hFF);
    row_tag = "R7";
    // Split at line 20; upper high-byte bits discarded.
    run_frame(38, 0, 20, 8'hEA, 8'h55);
    // Value 37h matches lines 55 and 311 (R0 capture on the last line).
    run_frame(38, 0, 8'h37, 8'h13, 8'h80);
    run_frame(38, 0, 0, 8'h00, 8'h00);
    // Soft scroll moves the row end one raster earlier.
    scr = 1;
    run_frame(38, 0, 0, 8'h00, 8'h00);
    scr = 0;
    // Adjust frames: 304 lines + 16 adjust lines.
    run_frame(37, 16, 53, 8'h0C, 8'h00);
    run_frame(37, 16, 58, 8'h0D, 8'h00);
    run_frame(38, 0, 0, 8'h00, 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule